// File: doc/BRIEF.md
# Pulse-pair to step/direction converter

This block accepts two motion command lines from a pulse-train source. One line carries clockwise steps and the other counterclockwise steps. It turns them into a single step clock, a direction level that is held between pulses, and a fault flag. A static polarity input selects between two conventions. In the active-high convention both lines rest low and pulse high. In the active-low convention both lines rest high and pulse low. The step output keeps the same polarity as the inputs.

Each line is first brought into the system clock domain by a two-flop synchronizer. The synchronized lines are then decoded in one registered stage that produces the direction, the fault flag and an undelayed step level. The step level then passes through a programmable delay of `STEP_DELAY` system-clock cycles. As a result, a downstream counter always finds the direction settled before the step edge arrives. The fault flag is meant to feed an interrupt and to stop downstream counting. It stays set until software pulses a clear.

Top module: `pulse_dir_conv`

## Requirements
- R1: Each command line passes through two synchronizer flops and one decode register. A change on a line driven between clock edges therefore shows on `dir_out` at the third rising edge after it.
- R2: With `active_low` = 0, the step level is the OR of the two lines. With `active_low` = 1, it is the AND of the two lines, so it is high only while both lines idle high.
- R3: `step_out` follows the decoded step level `STEP_DELAY` cycles later than `dir_out`. A line change reaches `step_out` at rising edge 3 + `STEP_DELAY`.
- R4: With `active_low` = 0, the clockwise line high alone sets `dir_out` to 0, and the counterclockwise line high alone sets it to 1.
- R5: With `active_low` = 1, the clockwise line low alone sets `dir_out` to 0, and the counterclockwise line low alone sets it to 1.
- R6: While neither line is active, `dir_out` keeps its previous value.
- R7: While both lines are active together, `fault_out` is set and `dir_out` keeps its last valid value.
- R8: `fault_out` stays set after the lines return to idle and clears only after a `fault_clr` pulse. If both lines are active in the same cycle as a clear, the flag stays set.
- R9: A synchronous reset drives `dir_out` to 0 and `fault_out` to 0, and puts `step_out` at the idle level of the selected polarity (equal to `active_low`). `active_low` is held static while out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| active_low | input | 1 | Polarity select: 0 = lines idle low, 1 = lines idle high |
| cw_in | input | 1 | Clockwise command line, asynchronous |
| ccw_in | input | 1 | Counterclockwise command line, asynchronous |
| fault_clr | input | 1 | Single-cycle clear of the sticky fault flag |
| step_out | output | 1 | Delayed step clock, same polarity as the inputs |
| dir_out | output | 1 | Held direction: 0 = clockwise, 1 = counterclockwise |
| fault_out | output | 1 | Sticky flag for simultaneous activity |

## Verification
The bench sweeps both polarities, both prior directions and all four combinations of line activity. This separates the OR from the AND step level and the set, reset and hold cases of the direction. It also shows that the fault case leaves the prior direction untouched.

After each pattern the lines return to idle, to show that direction and fault survive the idle period. A clear then shows that the fault drops only on request. A clear issued while both lines are active shows that setting the fault takes priority over clearing it. Edge counts from a line change to `dir_out` and to `step_out` separate the synchronizer depth from the step delay.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned DECODE_LAT  = SYNC_STAGES + 1;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CW   = 2'b01,
    ACT_CCW  = 2'b10,
    ACT_BOTH = 2'b11
  } act_e;

  localparam logic DIR_CW  = 1'b0;
  localparam logic DIR_CCW = 1'b1;

  // Translate a raw line level into an "active" flag for the chosen polarity.
  function automatic logic line_active(input logic lvl, input logic pol_low);
    return lvl ^ pol_low;
  endfunction
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rst_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= rst_val;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= rst_val;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdc_decode.sv
module pdc_decode
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active_low,
  input  logic cw_s,
  input  logic ccw_s,
  input  logic fault_clr,
  output logic dir_q,
  output logic fault_q,
  output logic step_q
);
  logic cw_a, ccw_a, any_a, both_a;
  act_e act;

  always_comb begin
    cw_a   = line_active(cw_s, active_low);
    ccw_a  = line_active(ccw_s, active_low);
    any_a  = cw_a | ccw_a;
    both_a = cw_a & ccw_a;
    act    = act_e'({ccw_a, cw_a});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_CW;
      fault_q <= 1'b0;
      step_q  <= active_low;
    end else begin
      // Active-high: OR of lines. Active-low: AND of lines (high only when both idle).
      step_q  <= any_a ^ active_low;
      fault_q <= both_a | (fault_q & ~fault_clr);
      unique case (act)
        ACT_CW:  dir_q <= DIR_CW;
        ACT_CCW: dir_q <= DIR_CCW;
        default: dir_q <= dir_q;
      endcase
    end
  end

  assert_reset_clears_R9: assert property (@(posedge clk) rst |=> (!dir_q && !fault_q));
  assert_fault_set_R7: assert property (@(posedge clk) disable iff (rst) both_a |=> fault_q);
  assert_dir_hold_fault_R7: assert property (@(posedge clk) disable iff (rst) both_a |=> $stable(dir_q));
  assert_dir_hold_idle_R6: assert property (@(posedge clk) disable iff (rst) !any_a |=> $stable(dir_q));
  assert_dir_cw_R4: assert property (@(posedge clk) disable iff (rst) (cw_a && !ccw_a) |=> (dir_q == DIR_CW));
  assert_dir_ccw_R5: assert property (@(posedge clk) disable iff (rst) (ccw_a && !cw_a) |=> (dir_q == DIR_CCW));
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst) (fault_q && !fault_clr) |=> fault_q);
endmodule

// File: rtl/pdc_delay.sv
module pdc_delay #(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_line
      logic [DEPTH-1:0] sr;
      if (DEPTH == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (rst) sr <= rst_val;
          else     sr <= d;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (rst) sr <= {DEPTH{rst_val}};
          else     sr <= {sr[DEPTH-2:0], d};
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pulse_dir_conv.sv
module pulse_dir_conv
  import pdc_pkg::*;
#(
  parameter int unsigned STEP_DELAY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic active_low,
  input  logic cw_in,
  input  logic ccw_in,
  input  logic fault_clr,
  output logic step_out,
  output logic dir_out,
  output logic fault_out
);
  logic [1:0] lines_s;
  logic       step_undelayed;

  pdc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val ({2{active_low}}),
    .d       ({ccw_in, cw_in}),
    .q       (lines_s)
  );

  pdc_decode u_dec (
    .clk        (clk),
    .rst        (rst),
    .active_low (active_low),
    .cw_s       (lines_s[0]),
    .ccw_s      (lines_s[1]),
    .fault_clr  (fault_clr),
    .dir_q      (dir_out),
    .fault_q    (fault_out),
    .step_q     (step_undelayed)
  );

  pdc_delay #(.DEPTH(STEP_DELAY)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .rst_val (active_low),
    .d       (step_undelayed),
    .q       (step_out)
  );

  assert_step_idle_after_reset_R9: assert property (@(posedge clk) rst |=> (step_out == active_low));
endmodule

// File: tb/pulse_dir_conv_test.sv
`timescale 1ns/100ps
module pulse_dir_conv_test;
  localparam int D    = 4;
  localparam int HOLD = 3 + D + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic active_low = 1'b0;
  logic cw_in = 1'b0, ccw_in = 1'b0, fault_clr = 1'b0;
  logic step_out, dir_out, fault_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_dir_conv #(.STEP_DELAY(D)) uut (
    .clk(clk), .rst(rst), .active_low(active_low), .cw_in(cw_in), .ccw_in(ccw_in),
    .fault_clr(fault_clr), .step_out(step_out), .dir_out(dir_out), .fault_out(fault_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit cw_act, input bit ccw_act);
    @(negedge clk);
    cw_in  = cw_act ^ active_low;
    ccw_in = ccw_act ^ active_low;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    wait_n(2);
  endtask

  task automatic do_reset(input bit pol);
    @(negedge clk);
    rst = 1'b1; active_low = pol; cw_in = pol; ccw_in = pol; fault_clr = 1'b0;
    wait_n(2);
    @(negedge clk); rst = 1'b0;
    #1;
  endtask

  initial begin
    for (int pol = 0; pol < 2; pol++) begin
      do_reset(pol[0]);
      check("R9 dir after reset", dir_out, 0);
      check("R9 fault after reset", fault_out, 0);
      check("R9 step idle level", step_out, pol);
      for (int prior = 0; prior < 2; prior++) begin
        for (int a = 0; a < 4; a++) begin
          int dir_exp;
          // establish prior direction
          drive(prior == 0, prior == 1);
          wait_n(HOLD);
          drive(0, 0);
          wait_n(HOLD);
          pulse_clear();
          check("R6 prior dir established", dir_out, prior);
          // apply pattern
          drive(a[0], a[1]);
          wait_n(HOLD);
          dir_exp = (a == 1) ? 0 : (a == 2) ? 1 : prior;
          check("R2 step level", step_out, ((a != 0) ? 1 : 0) ^ pol);
          check(pol ? "R5 dir active-low" : "R4 dir active-high", dir_out, dir_exp);
          check("R7 fault on both", fault_out, (a == 3) ? 1 : 0);
          if (a == 3) begin
            // clear while still both active: set wins
            @(negedge clk); fault_clr = 1'b1;
            @(negedge clk); fault_clr = 1'b0;
            wait_n(1);
            check("R8 set beats clear", fault_out, 1);
          end
          drive(0, 0);
          wait_n(HOLD);
          check("R6 dir held in idle", dir_out, dir_exp);
          check("R8 fault sticky in idle", fault_out, (a == 3) ? 1 : 0);
          check("R2 step idle", step_out, pol);
          pulse_clear();
          check("R8 fault cleared", fault_out, 0);
        end
      end
      // latency: prior dir = 1, then clockwise pulse
      begin
        int n_dir = 0, n_step = 0, n = 0;
        drive(0, 1); wait_n(HOLD); drive(0, 0); wait_n(HOLD);
        drive(1, 0);
        while (n < 40 && (n_dir == 0 || n_step == 0)) begin
          @(posedge clk); #1; n++;
          if (n_dir == 0 && dir_out == 0) n_dir = n;
          if (n_step == 0 && step_out != pol[0]) n_step = n;
        end
        check("R1 dir latency", n_dir, 3);
        check("R3 step latency", n_step, 3 + D);
        drive(0, 0); wait_n(HOLD);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule